// File: doc/BRIEF.md
# Self-Calibrating Min/Max Threshold Controller

This block sets the switching point of a magnetic-edge comparator from a stream of digitized field samples. It records the lowest and highest sample seen in a window and forms a weighted threshold between them. It then moves a 10-bit offset code toward that threshold. The offset code shifts the analog signal so that the comparator trips at the chosen level. A switching-event strobe from the comparator output, together with rising and falling slope flags from the converter, paces the whole process.

After reset the controller is in phase INIT (code 0). It loads a start value and moves to FAST (code 1). In FAST, every slope flag may trigger a clamped correction. After 16 switching events it moves to ONCE (code 2), where a single clamped correction is allowed. After 16 more switching events it moves to CAL (code 3). In CAL the code moves by at most one LSB per window of 32 switching events, and only after four windows agree on the direction.

Two monitors send the controller back to INIT from any other phase:
- a watchdog that fires when no switching event occurs for a set time;
- a miss counter that fires on the fourth slope flag with no switching event in between.

The transitions are:
- INIT→FAST on start load.
- FAST→ONCE on the 16th event.
- ONCE→CAL on the 16th event.
- any→INIT on a monitor trip.

Top module: `thresh_tracker`

## Requirements
- R1: While reset is asserted, `phase` is 0 (INIT) and `ofs_code` is midscale, 512.
- R2: In INIT with `prog_en`=1, the next clock loads `static_code` into `ofs_code` and sets phase 1 (FAST). With `prog_en`=0, INIT waits for a valid sample, then loads that sample code and sets phase 1.
- R3: The target is lo + floor((hi−lo)·w/256). Here w = 86 + 16·`k_code` when `prog_en`=1 (33.59% to 77.34% in 6.25% steps), and w = 128 when `prog_en`=0. The values hi and lo are the window maximum and minimum.
- R4: In FAST, a slope flag with at least one sample in the window moves `ofs_code` toward the target by min(|target − ofs|, 118). The update is visible one clock later.
- R5: An increase is applied only on `edge_rise`, and a decrease only on `edge_fall`. A flag in the wrong direction leaves `ofs_code` unchanged.
- R6: The 16th switching event in FAST clears the window and sets phase 2 (ONCE). In ONCE, only the first qualifying slope flag corrects, with the same clamp. A slope flag with an empty window does nothing.
- R7: The 16th switching event in ONCE clears the window and sets phase 3 (CAL). Phases only advance by one or return to INIT.
- R8: In CAL, each 32nd switching event closes a window and computes the adjustment sign. `ofs_code` steps by exactly 1 toward the target when the current window is the fourth or later consecutive window with the same sign.
- R9: In CAL, a window whose |target − ofs| is below 2 (or that has no samples) is ignored. It changes neither `ofs_code` nor the agreement count.
- R10: With a clock of CLK_HZ, the controller returns to INIT when WDOG_MS milliseconds pass with no `sw_evt`. On that return `ofs_code` goes back to 512.
- R11: The fourth slope flag since the last `sw_evt` returns the controller to INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | 10 | Digitized field sample, offset code |
| edge_rise | input | 1 | Rising-slope flag (minimum passed) |
| edge_fall | input | 1 | Falling-slope flag (maximum passed) |
| sw_evt | input | 1 | Output switching-event strobe |
| prog_en | input | 1 | Device holds a stored threshold and weight |
| static_code | input | 10 | Stored start threshold |
| k_code | input | 3 | Stored weight code |
| ofs_code | output | 10 | Offset code driving the switching point |
| phase | output | 2 | 0 INIT, 1 FAST, 2 ONCE, 3 CAL |

## Verification
Several properties are checked on every cycle:
- No move in FAST or ONCE without a slope flag.
- The sign of each move matches the flag.
- The 118-code clamp.
- The one-LSB step limit in CAL.
- Legal phase ordering.

The bench scenarios show what needs a whole history:
- Target arithmetic across all eight weight codes.
- The single correction in ONCE.
- The exact event counts at each phase boundary.
- Four-window agreement.
- An ignored window keeping the agreement count.
- Both monitors firing at their limits.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [1:0] {
        PH_INIT = 2'd0,
        PH_FAST = 2'd1,
        PH_ONCE = 2'd2,
        PH_CAL  = 2'd3
    } phase_t;

    // Weight out of 256: 86 + 16*code when stored, 128 (half) otherwise.
    function automatic logic [8:0] weight_of(input logic stored, input logic [2:0] code);
        return stored ? (9'd86 + {2'b00, code, 4'b0000}) : 9'd128;
    endfunction

endpackage

// File: rtl/thr_extrema.sv
module thr_extrema #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_code,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo,
    output logic         seen
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi   <= '0;
            lo   <= '1;
            seen <= 1'b0;
        end else if (clr) begin
            hi   <= '0;
            lo   <= '1;
            seen <= 1'b0;
        end else if (smp_valid) begin
            if (smp_code > hi) hi <= smp_code;
            if (smp_code < lo) lo <= smp_code;
            seen <= 1'b1;
        end
    end
endmodule

// File: rtl/thr_target.sv
module thr_target #(
    parameter int W = 10
) (
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [8:0]   wt,
    output logic [W-1:0] tgt
);
    logic [W-1:0] span;
    logic [W+8:0] prod;

    always_comb begin
        span = hi - lo;
        prod = {9'b0, span} * {{W{1'b0}}, wt};
        tgt  = lo + prod[W+7:8];
    end
endmodule

// File: rtl/thr_monitor.sv
module thr_monitor #(
    parameter int TICK_DIV   = 50000,
    parameter int WDOG_TICKS = 12000,
    parameter int MISS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sw_evt,
    input  logic extremum,
    output logic trip
);
    localparam int PRE_W  = $clog2(TICK_DIV);
    localparam int WD_W   = $clog2(WDOG_TICKS + 1);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);

    logic [PRE_W-1:0]  pre_cnt;
    logic [WD_W-1:0]   wd_cnt;
    logic [MISS_W-1:0] miss_cnt;
    logic              tick;

    assign tick = (pre_cnt == PRE_W'(TICK_DIV - 1));
    assign trip = run && !sw_evt &&
                  ((tick && (wd_cnt == WD_W'(WDOG_TICKS - 1))) ||
                   (extremum && (miss_cnt == MISS_W'(MISS_LIMIT - 1))));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            wd_cnt   <= '0;
            miss_cnt <= '0;
        end else if (!run || sw_evt || trip) begin
            pre_cnt  <= '0;
            wd_cnt   <= '0;
            miss_cnt <= '0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
            if (tick) wd_cnt <= wd_cnt + 1'b1;
            if (extremum) miss_cnt <= miss_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/thresh_tracker.sv
module thresh_tracker
    import thr_pkg::*;
#(
    parameter int CODE_W        = 10,
    parameter int CLAMP         = 118,
    parameter int PHASE_EVENTS  = 16,
    parameter int WIN_EVENTS    = 32,
    parameter int AGREE_WINDOWS = 4,
    parameter int ACT_LEVEL     = 2,
    parameter int MISS_LIMIT    = 4,
    parameter int CLK_HZ        = 50_000_000,
    parameter int TICK_HZ       = 1000,
    parameter int WDOG_MS       = 12000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              edge_rise,
    input  logic              edge_fall,
    input  logic              sw_evt,
    input  logic              prog_en,
    input  logic [CODE_W-1:0] static_code,
    input  logic [2:0]        k_code,
    output logic [CODE_W-1:0] ofs_code,
    output logic [1:0]        phase
);
    localparam int TICK_DIV   = CLK_HZ / TICK_HZ;
    localparam int WDOG_TICKS = (WDOG_MS * TICK_HZ) / 1000;
    localparam int EV_MAX     = (PHASE_EVENTS > WIN_EVENTS) ? PHASE_EVENTS : WIN_EVENTS;
    localparam int EV_W       = $clog2(EV_MAX);
    localparam int STK_W      = $clog2(AGREE_WINDOWS + 1);
    localparam logic [CODE_W-1:0] MID     = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W:0]   CLAMP_V = (CODE_W+1)'(CLAMP);
    localparam logic [CODE_W:0]   ACT_V   = (CODE_W+1)'(ACT_LEVEL);

    phase_t            state, nxt;
    logic [CODE_W-1:0] ofs_q;
    logic [EV_W-1:0]   ev_cnt;
    logic              once_used;
    logic [STK_W-1:0]  streak, streak_nx;
    logic              last_up;

    logic [CODE_W-1:0] win_hi, win_lo, tgt;
    logic              win_seen, win_clr;
    logic [8:0]        wt;
    logic              ext_evt, trip, mon_run;
    logic [CODE_W:0]   diff, mag;
    logic [CODE_W-1:0] step;
    logic              adj_up, adj_dn;
    logic              phase_end, win_end, pre_ok, act_ok;

    assign ofs_code = ofs_q;
    assign phase    = state;
    assign wt       = weight_of(prog_en, k_code);
    assign ext_evt  = edge_rise | edge_fall;
    assign mon_run  = (state != PH_INIT);

    thr_extrema #(.W(CODE_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .clr(win_clr),
        .smp_valid(smp_valid), .smp_code(smp_code),
        .hi(win_hi), .lo(win_lo), .seen(win_seen)
    );

    thr_target #(.W(CODE_W)) u_tgt (
        .hi(win_hi), .lo(win_lo), .wt(wt), .tgt(tgt)
    );

    thr_monitor #(
        .TICK_DIV(TICK_DIV), .WDOG_TICKS(WDOG_TICKS), .MISS_LIMIT(MISS_LIMIT)
    ) u_mon (
        .clk(clk), .rst_n(rst_n), .run(mon_run),
        .sw_evt(sw_evt), .extremum(ext_evt), .trip(trip)
    );

    // Correction arithmetic
    always_comb begin
        diff   = {1'b0, tgt} - {1'b0, ofs_q};
        mag    = diff[CODE_W] ? (~diff + 1'b1) : diff;
        adj_up = !diff[CODE_W] && (diff != '0);
        adj_dn = diff[CODE_W];
        step   = (mag > CLAMP_V) ? CLAMP_V[CODE_W-1:0] : mag[CODE_W-1:0];

        phase_end = sw_evt && (ev_cnt == EV_W'(PHASE_EVENTS - 1));
        win_end   = (state == PH_CAL) && sw_evt && (ev_cnt == EV_W'(WIN_EVENTS - 1));
        pre_ok    = ((state == PH_FAST) || ((state == PH_ONCE) && !once_used)) &&
                    win_seen && ((edge_rise && adj_up) || (edge_fall && adj_dn));
        act_ok    = win_seen && (mag >= ACT_V);

        if ((streak != '0) && (last_up == adj_up))
            streak_nx = (streak == STK_W'(AGREE_WINDOWS)) ? streak : streak + 1'b1;
        else
            streak_nx = STK_W'(1);
    end

    // Next phase
    always_comb begin
        nxt = state;
        if ((state != PH_INIT) && trip) begin
            nxt = PH_INIT;
        end else begin
            unique case (state)
                PH_INIT: if (prog_en || smp_valid) nxt = PH_FAST;
                PH_FAST: if (phase_end) nxt = PH_ONCE;
                PH_ONCE: if (phase_end) nxt = PH_CAL;
                PH_CAL:  nxt = PH_CAL;
            endcase
        end
    end

    assign win_clr = (state == PH_INIT) || (nxt != state) || win_end;

    // Phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_INIT;
        else        state <= nxt;
    end

    // Offset code, event counter and agreement filter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q     <= MID;
            ev_cnt    <= '0;
            once_used <= 1'b0;
            streak    <= '0;
            last_up   <= 1'b0;
        end else if ((state != PH_INIT) && trip) begin
            ofs_q     <= MID;
            ev_cnt    <= '0;
            once_used <= 1'b0;
            streak    <= '0;
            last_up   <= 1'b0;
        end else begin
            unique case (state)
                PH_INIT: begin
                    ev_cnt    <= '0;
                    once_used <= 1'b0;
                    streak    <= '0;
                    last_up   <= 1'b0;
                    if (prog_en)        ofs_q <= static_code;
                    else if (smp_valid) ofs_q <= smp_code;
                end
                PH_FAST, PH_ONCE: begin
                    if (sw_evt) ev_cnt <= phase_end ? '0 : ev_cnt + 1'b1;
                    if (pre_ok) begin
                        ofs_q <= adj_up ? ofs_q + step : ofs_q - step;
                        if (state == PH_ONCE) once_used <= 1'b1;
                    end
                end
                PH_CAL: begin
                    if (sw_evt) ev_cnt <= win_end ? '0 : ev_cnt + 1'b1;
                    if (win_end && act_ok) begin
                        streak  <= streak_nx;
                        last_up <= adj_up;
                        if (streak_nx == STK_W'(AGREE_WINDOWS))
                            ofs_q <= adj_up ? ofs_q + 1'b1 : ofs_q - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/thresh_tracker_chk.sv
module thresh_tracker_chk #(
    parameter int CODE_W = 10,
    parameter int CLAMP  = 118
) (
    input logic              clk,
    input logic              rst_n,
    input logic              edge_rise,
    input logic              edge_fall,
    input logic [1:0]        phase,
    input logic [CODE_W-1:0] ofs_code
);
    logic pre_phase;
    assign pre_phase = (phase == 2'd1) || (phase == 2'd2);

    // R4/R6: no movement in FAST/ONCE without a slope flag
    a_r4_move_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_phase && !edge_rise && !edge_fall) |=> ((phase == 2'd0) || $stable(ofs_code)));

    // R5: a rising flag never lowers the code
    a_r5_rise_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_phase && edge_rise) |=> ((phase == 2'd0) || (ofs_code >= $past(ofs_code))));

    // R5: a falling flag never raises the code
    a_r5_fall_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_phase && edge_fall) |=> ((phase == 2'd0) || (ofs_code <= $past(ofs_code))));

    // R4: each correction is clamped
    a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        pre_phase |=> ((phase == 2'd0) ||
            (((ofs_code >= $past(ofs_code)) ? (ofs_code - $past(ofs_code))
                                            : ($past(ofs_code) - ofs_code)) <= CODE_W'(CLAMP))));

    // R8: calibrated steps are at most one LSB
    a_r8_one_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3) |=> ((phase == 2'd0) ||
            (((ofs_code >= $past(ofs_code)) ? (ofs_code - $past(ofs_code))
                                            : ($past(ofs_code) - ofs_code)) <= CODE_W'(1))));

    // R7: phase advances by one or falls back to INIT
    a_r7_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'd0) |=> ((phase == $past(phase)) || (phase == $past(phase) + 2'd1) ||
                             (phase == 2'd0)));
endmodule

bind thresh_tracker thresh_tracker_chk #(.CODE_W(CODE_W), .CLAMP(CLAMP)) u_chk (
    .clk(clk), .rst_n(rst_n), .edge_rise(edge_rise), .edge_fall(edge_fall),
    .phase(phase), .ofs_code(ofs_code)
);

// File: tb/sim_thresh_tracker.sv
module sim_thresh_tracker;
    localparam int DIV = 4;
    localparam int WD  = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [9:0] smp_code = '0;
    logic       edge_rise = 1'b0;
    logic       edge_fall = 1'b0;
    logic       sw_evt = 1'b0;
    logic       prog_en = 1'b0;
    logic [9:0] static_code = '0;
    logic [2:0] k_code = '0;
    logic [9:0] ofs_code;
    logic [1:0] phase;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thresh_tracker #(.CLK_HZ(4000), .TICK_HZ(1000), .WDOG_MS(50)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .edge_rise(edge_rise), .edge_fall(edge_fall), .sw_evt(sw_evt),
        .prog_en(prog_en), .static_code(static_code), .k_code(k_code),
        .ofs_code(ofs_code), .phase(phase)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tgt_of(input int lo, input int hi, input bit stored, input int k);
        int w;
        w = stored ? (86 + 16 * k) : 128;
        return lo + ((hi - lo) * w) / 256;
    endfunction

    function automatic int toward(input int cur, input int t);
        int d;
        d = t - cur;
        if (d > 118) d = 118;
        if (d < -118) d = -118;
        return cur + d;
    endfunction

    task automatic smp(input int v);
        @(negedge clk); smp_valid = 1'b1; smp_code = 10'(v);
        @(negedge clk); smp_valid = 1'b0;
    endtask
    task automatic rise();
        @(negedge clk); edge_rise = 1'b1;
        @(negedge clk); edge_rise = 1'b0;
    endtask
    task automatic fall();
        @(negedge clk); edge_fall = 1'b1;
        @(negedge clk); edge_fall = 1'b0;
    endtask
    task automatic sw();
        @(negedge clk); sw_evt = 1'b1;
        @(negedge clk); sw_evt = 1'b0;
    endtask

    task automatic do_reset(input bit p, input int s, input int k);
        @(negedge clk);
        rst_n = 1'b0; prog_en = p; static_code = 10'(s); k_code = 3'(k);
        @(negedge clk);
        check("R1 phase in reset", phase, 0);
        check("R1 code in reset", ofs_code, 512);
        rst_n = 1'b1;
    endtask

    int exp_ofs, t, streak_m, d;
    bit last_m;

    task automatic cal_window(input int lo, input int hi);
        smp(lo);
        smp(hi);
        repeat (32) sw();
        t = tgt_of(lo, hi, 1'b1, 7);
        d = t - exp_ofs;
        if (d >= 2 || d <= -2) begin
            if (streak_m > 0 && last_m == (d > 0)) begin
                if (streak_m < 4) streak_m++;
            end else begin
                streak_m = 1;
                last_m = (d > 0);
            end
            if (streak_m == 4) exp_ofs += (d > 0) ? 1 : -1;
        end
        check("R8/R9 calibrated window", ofs_code, exp_ofs);
        check("R7 stays in CAL", phase, 3);
    endtask

    initial begin
        // R2, R3, R4, R5: sweep of all weight codes in FAST
        for (int k = 0; k < 8; k++) begin
            do_reset(1'b1, 200, k);
            @(negedge clk);
            check("R2 programmed start phase", phase, 1);
            check("R2 programmed start code", ofs_code, 200);
            smp(100);
            smp(900);
            t = tgt_of(100, 900, 1'b1, k);
            exp_ofs = 200;
            for (int i = 0; i < 3; i++) begin
                rise();
                exp_ofs = toward(exp_ofs, t);
                check("R3 R4 clamped rise update", ofs_code, exp_ofs);
                sw();
            end
            fall();
            check("R5 fall ignored when target above", ofs_code, exp_ofs);
            sw();
        end

        // R2 unprogrammed start, R4/R5 decreasing path
        do_reset(1'b0, 0, 0);
        @(negedge clk);
        check("R2 unprogrammed waits", phase, 0);
        smp(1000);
        check("R2 sample start phase", phase, 1);
        check("R2 sample start code", ofs_code, 1000);
        smp(200);
        smp(600);
        t = tgt_of(200, 600, 1'b0, 0);
        exp_ofs = 1000;
        rise();
        check("R5 rise ignored when target below", ofs_code, exp_ofs);
        sw();
        for (int i = 0; i < 6; i++) begin
            fall();
            exp_ofs = toward(exp_ofs, t);
            check("R4 clamped fall update", ofs_code, exp_ofs);
            sw();
        end

        // R10 watchdog
        repeat (DIV * WD - 3) @(negedge clk);
        check("R10 before expiry", phase, 1);
        repeat (4) @(negedge clk);
        check("R10 watchdog to INIT", phase, 0);
        check("R10 code back to midscale", ofs_code, 512);

        // R11 miss monitor
        smp(700);
        check("R11 restart", phase, 1);
        rise(); rise(); rise();
        check("R11 three flags tolerated", phase, 1);
        sw();
        fall(); fall(); fall();
        check("R11 count cleared by switching", phase, 1);
        fall();
        check("R11 fourth flag to INIT", phase, 0);

        // R6, R7: single update phase and entry to CAL
        do_reset(1'b1, 200, 7);
        @(negedge clk);
        repeat (15) sw();
        check("R6 still FAST after 15", phase, 1);
        sw();
        check("R6 ONCE after 16", phase, 2);
        rise();
        check("R6 empty window no update", ofs_code, 200);
        smp(300);
        smp(500);
        rise();
        exp_ofs = toward(200, tgt_of(300, 500, 1'b1, 7));
        check("R6 single update", ofs_code, exp_ofs);
        sw();
        smp(100);
        smp(1000);
        rise();
        check("R6 second update blocked", ofs_code, exp_ofs);
        sw();
        repeat (13) sw();
        check("R7 still ONCE after 15", phase, 2);
        sw();
        check("R7 CAL after 16", phase, 3);

        // R8, R9: calibrated filter
        streak_m = 0;
        last_m = 1'b0;
        for (int i = 0; i < 5; i++) cal_window(300, 500);
        cal_window(100, 200);
        cal_window(exp_ofs + 1, exp_ofs + 1);
        check("R9 ignored window, code", ofs_code, exp_ofs);
        for (int i = 0; i < 3; i++) cal_window(100, 200);
        check("R8 four agreeing downward windows", ofs_code, 319);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule